// File: doc/BRIEF.md
# Pseudo-Random Noise Channel

This block is the noise voice of a sound generator. A down-counting period timer runs from a table of sixteen preset periods, selected by a 4-bit code. Each time the timer expires, a 15-bit linear feedback shift register advances by one step. A mode input picks the feedback tap: the long tap gives a sequence of 32767 steps, and the short tap gives a short, buzzy loop.

The low bit of the shift register gates a 4-bit volume onto the amplitude output. When that bit is 0 and the channel is enabled, the volume appears at the output. Envelope shaping and note-length timing are handled elsewhere, so the volume arrives here as a plain input.

The period code and the mode are sampled only when the timer expires. Changing them never disturbs the shift register contents, and never cuts short the count already in progress.

Top module: `noise_lfsr_chan`

## Requirements
- R1: While `rst_n` is low, and after its release until the first rising clock edge, the shift register holds 0x0001, the timer count is 1 and `amp` is 0.
- R2: The first rising edge after reset release is a timer expiry. In long mode, that shift turns the register into 0x4000, so `amp` equals `volume` (when `enable` is high) from that edge on.
- R3: In long mode (`short_mode`=0), each expiry shifts the register right by one bit. The new bit 14 is bit 0 XOR bit 1, and the register never becomes zero.
- R4: In short mode (`short_mode`=1), the new bit 14 is bit 0 XOR bit 6. Starting from 0x0001, the sequence repeats every 93 shifts.
- R5: Expiries are spaced N cycles apart. N is the table entry for `period_sel` codes 0 through 15: 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068. Between expiries the register holds.
- R6: `amp` equals `volume` when `enable` is 1 and register bit 0 is 0. Otherwise `amp` is 0.
- R7: `enable` low forces `amp` to 0 but leaves the register and timer running. When `enable` returns high, the output continues the undisturbed sequence.
- R8: `period_sel` is read only at an expiry, to reload the timer. A change that arrives on the expiry cycle itself applies to that reload, and a change mid-count does not shorten the current count.
- R9: `short_mode` is read only at the moment of a shift. Changing it alters no register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 4 | Period table code |
| short_mode | input | 1 | 1 selects the bit-6 feedback tap |
| volume | input | 4 | Amplitude applied when the gate is open |
| enable | input | 1 | Channel enable |
| amp | output | 4 | Gated amplitude |

## Verification
Timer reload and feedback selection both fall on the expiry cycle. The bench therefore waits until its own count model shows the final cycle of a period. It then changes `period_sel` and `short_mode` together at that moment. The new reload length and the new tap must both appear in the output sequence that follows, which is judged cycle by cycle against an arithmetic model of the register and timer.

// File: rtl/noise_pkg.sv
package noise_pkg;
   localparam int NZ_SEL_W   = 4;
   localparam int NZ_TBL_W   = 12;
   localparam int NZ_MAX_PER = 4068;

   function automatic logic [NZ_TBL_W-1:0] nz_period(input logic [NZ_SEL_W-1:0] code);
      logic [NZ_TBL_W-1:0] p;
      case (code)
         4'd0:    p = 12'd4;
         4'd1:    p = 12'd8;
         4'd2:    p = 12'd16;
         4'd3:    p = 12'd32;
         4'd4:    p = 12'd64;
         4'd5:    p = 12'd96;
         4'd6:    p = 12'd128;
         4'd7:    p = 12'd160;
         4'd8:    p = 12'd202;
         4'd9:    p = 12'd254;
         4'd10:   p = 12'd380;
         4'd11:   p = 12'd508;
         4'd12:   p = 12'd762;
         4'd13:   p = 12'd1016;
         4'd14:   p = 12'd2034;
         default: p = 12'd4068;
      endcase
      return p;
   endfunction
endpackage

// File: rtl/nz_timer.sv
module nz_timer
   import noise_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < NZ_TBL_W) begin : g_bad_cnt
         $error("nz_timer: CNT_W too narrow for the period table");
      end
      if (SEL_W != NZ_SEL_W) begin : g_bad_sel
         $error("nz_timer: SEL_W must match the table index width");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign expire = (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= ONE;
      else if (expire) cnt <= CNT_W'(nz_period(sel));
      else             cnt <= cnt - ONE;
   end

   p_first_expiry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> expire);

   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) && (cnt <= CNT_W'(NZ_MAX_PER)));

   p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !expire |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/nz_lfsr.sv
module nz_lfsr #(
   parameter int W         = 15,
   parameter int TAP_LONG  = 1,
   parameter int TAP_SHORT = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic short_sel,
   output logic lsb
);
   generate
      if (TAP_LONG < 1 || TAP_LONG >= W) begin : g_bad_long
         $error("nz_lfsr: TAP_LONG out of range");
      end
      if (TAP_SHORT < 1 || TAP_SHORT >= W) begin : g_bad_short
         $error("nz_lfsr: TAP_SHORT out of range");
      end
   endgenerate

   logic [W-1:0] q;
   logic [W-1:0] nxt;
   logic         fb;

   assign fb = q[0] ^ (short_sel ? q[TAP_SHORT] : q[TAP_LONG]);

   generate
      for (genvar i = 0; i < W - 1; i++) begin : g_shift
         assign nxt[i] = q[i+1];
      end
   endgenerate
   assign nxt[W-1] = fb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= W'(1);
      else if (step) q <= nxt;
   end

   assign lsb = q[0];

   p_long_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step && !short_sel |=> q[W-1] == ($past(q[0]) ^ $past(q[TAP_LONG])));

   p_short_tap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step && short_sel |=> q[W-1] == ($past(q[0]) ^ $past(q[TAP_SHORT])));

   p_shift_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> q[W-2:0] == $past(q[W-1:1]));

   p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(q));

   always_ff @(posedge clk) begin
      if (rst_n) begin
         p_nonzero_r3: assert (q != '0) else $error("shift register reached zero");
      end
   end
endmodule

// File: rtl/nz_gate.sv
module nz_gate #(
   parameter int VOL_W = 4
) (
   input  logic             lsb,
   input  logic             enable,
   input  logic [VOL_W-1:0] volume,
   output logic [VOL_W-1:0] amp
);
   always_comb begin
      if (enable && !lsb) amp = volume;
      else                amp = '0;
   end
endmodule

// File: rtl/noise_lfsr_chan.sv
module noise_lfsr_chan #(
   parameter int LFSR_W    = 15,
   parameter int SEL_W     = 4,
   parameter int VOL_W     = 4,
   parameter int CNT_W     = 12,
   parameter int TAP_LONG  = 1,
   parameter int TAP_SHORT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] period_sel,
   input  logic             short_mode,
   input  logic [VOL_W-1:0] volume,
   input  logic             enable,
   output logic [VOL_W-1:0] amp
);
   logic expire;
   logic lsb;

   nz_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (period_sel),
      .expire (expire)
   );

   nz_lfsr #(.W(LFSR_W), .TAP_LONG(TAP_LONG), .TAP_SHORT(TAP_SHORT)) lfsr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (expire),
      .short_sel (short_mode),
      .lsb       (lsb)
   );

   nz_gate #(.VOL_W(VOL_W)) gate_i (
      .lsb    (lsb),
      .enable (enable),
      .volume (volume),
      .amp    (amp)
   );

   p_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> amp == '0);

   p_open_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      enable && !lsb |-> amp == volume);

   p_closed_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lsb |-> amp == '0);
endmodule

// File: tb/noise_lfsr_chan_tb.sv
`timescale 1ns/1ps
module noise_lfsr_chan_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] period_sel = 4'd0;
   logic       short_mode = 1'b0;
   logic [3:0] volume = 4'hF;
   logic       enable = 1'b1;
   logic [3:0] amp;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   int tbl [16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};

   int          m_cnt = 1;
   logic [14:0] m_lf = 15'h1;
   logic [3:0]  hist [372];

   always #2.5 clk = ~clk;

   noise_lfsr_chan dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_sel (period_sel),
      .short_mode (short_mode),
      .volume     (volume),
      .enable     (enable),
      .amp        (amp)
   );

   // arithmetic reference: count and shift per requirement text
   always @(posedge clk) begin
      logic fb;
      if (!rst_n) begin
         m_cnt = 1;
         m_lf  = 15'h1;
      end else if (m_cnt == 1) begin
         fb    = m_lf[0] ^ (short_mode ? m_lf[6] : m_lf[1]);
         m_lf  = {fb, m_lf[14:1]};
         m_cnt = tbl[period_sel];
      end else begin
         m_cnt = m_cnt - 1;
      end
   end

   function automatic logic [3:0] exp_amp();
      return (enable && !m_lf[0]) ? volume : 4'h0;
   endfunction

   task automatic cmp(input string req, input logic [3:0] exp);
      vectors++;
      if (amp !== exp) begin
         fails++;
         $display("FAIL %s amp=%h expected=%h at %0t", req, amp, exp, $time);
      end
   endtask

   task automatic run(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cmp(req, exp_amp());
      end
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0;
      short_mode = mode;
      period_sel = 4'd0;
      enable = 1'b1;
      volume = 4'hF;
      repeat (2) @(posedge clk);
      @(negedge clk);
      cmp("R1", 4'h0);
      rst_n = 1'b1;
      #1;
      cmp("R1", 4'h0);
   endtask

   initial begin
      // R1 and R2: reset and first shift
      do_reset(1'b0);
      @(negedge clk);
      cmp("R2", 4'hF);
      run(3, "R5");

      // R3 and R6: long mode, varying volume
      for (int v = 0; v < 16; v++) begin
         volume = 4'(v);
         run(120, "R3");
      end

      // R5 and R8: sweep every code in both modes, changes land mid-count
      for (int m = 0; m < 2; m++) begin
         short_mode = 1'(m);
         for (int s = 0; s < 16; s++) begin
            period_sel = 4'(s);
            volume = 4'(15 - s);
            run(3 * tbl[s] + 5, "R5");
         end
      end

      // R7: mute and resume
      period_sel = 4'd0;
      short_mode = 1'b0;
      volume = 4'hA;
      run(20, "R6");
      enable = 1'b0;
      run(37, "R7");
      enable = 1'b1;
      run(200, "R7");

      // R8 and R9: change code and mode exactly on the expiry cycle
      for (int t = 0; t < 12; t++) begin
         while (m_cnt != 1) run(1, "R8");
         period_sel = 4'(t % 4);
         short_mode = 1'(t % 2);
         run(tbl[t % 4] * 3, "R9");
      end

      // R4: short sequence repeats every 93 shifts (93 * 4 cycles)
      do_reset(1'b1);
      for (int k = 0; k < 372; k++) begin
         @(negedge clk);
         cmp("R4", exp_amp());
         hist[k] = amp;
      end
      for (int k = 0; k < 372; k++) begin
         @(negedge clk);
         cmp("R4", hist[k]);
      end

      // R1: reset in the middle of a run
      short_mode = 1'b0;
      period_sel = 4'd5;
      run(150, "R5");
      do_reset(1'b0);
      @(negedge clk);
      cmp("R2", 4'hF);
      run(50, "R3");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule